// File: doc/BRIEF.md
# Frame Pixel Grabber

This block lets a host pull a complete image out of a streaming imager one pixel per frame, through a single 8-bit register. An internal index counter names the pixel to take next. Once the grabber is armed, it waits for the start of a new frame. It then watches the pixel stream and latches the one pixel whose index matches the counter. The register then shows that pixel with its top bit set.

A host read that finds a valid pixel consumes it. The counter moves on to the next index and the grabber rearms for the following frame. A host write restarts the sequence from pixel 0. For a 15x15 array, 225 consuming reads return the whole image. The counter then wraps to 0 and the upload can start again.

Top module: `pixel_grabber`

## Requirements
- R1: After synchronous reset the register reads 0x00, the index counter is 0 and the grabber waits for a frame start.
- R2: The register layout is bit 7 = valid flag and bits 6:0 = pixel value. The cycle after a capture it reads {1, pixel value}. Whenever the valid flag is 0 it reads 0x00.
- R3: After arming, pixel strobes are ignored until a frame-start strobe has been seen. A pixel strobe that arrives in the same cycle as that frame start is also ignored.
- R4: Within a frame, only a pixel strobe whose index equals the counter is captured. Strobes with any other index leave the register unchanged.
- R5: A read while the valid flag is 1 clears the flag, so the register reads 0x00 the next cycle. The same read advances the counter by one and rearms the grabber to wait for the next frame start.
- R6: A read while the valid flag is 0 leaves the counter unchanged, and the next capture uses the same index.
- R7: The counter covers 0 to 224. The read that consumes pixel 224 wraps it to 0.
- R8: A write clears the register to 0x00, sets the counter to 0 and rearms the grabber to wait for a frame start. A write takes priority over a read in the same cycle.
- R9: While a valid pixel is held, further pixel or frame-start strobes do not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pix_valid | input | 1 | Pixel stream strobe |
| pix_idx | input | 8 | Index of the streamed pixel (0..224) |
| pix_data | input | 7 | Value of the streamed pixel |
| rd_stb | input | 1 | Host read strobe for the grab register |
| wr_stb | input | 1 | Host write strobe for the grab register |
| grab_reg | output | 8 | Grab register: {valid, pixel value} |

## Verification
The bench targets these corner cases:

- A pixel with the right index that arrives before, or together with, the frame start. A grabber that captures partway through a frame would show a valid pixel too early.
- A read that finds no valid pixel. A design that advanced on every read would then take the next pixel from the wrong index.
- A write that coincides with a read, and a write that arrives in the middle of a frame. Either could leave a stale index or capture without a fresh frame start.
- A full 225-frame upload followed by one more frame. This exposes a counter that stops at 224 or overflows past it instead of wrapping to 0.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int GRID_DEF  = 15;
    localparam int PIX_W_DEF = 7;

    typedef enum logic [1:0] {
        ARM_WAIT = 2'd0,
        ARM_SEEK = 2'd1,
        ARM_HELD = 2'd2
    } arm_state_e;

    typedef struct packed {
        logic rearm;     // host write: restart at index 0
        logic consume;   // host read of a held pixel
        logic hit;       // matching pixel seen during a frame
    } grab_ctl_t;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/pg_index_counter.sv
module pg_index_counter #(
    parameter int NUM_PIX = 225,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] cnt
);
    import pg_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= IDX_W'(wrap_inc(int'(cnt), NUM_PIX));
        end
    end

endmodule

// File: rtl/pg_arm_fsm.sv
module pg_arm_fsm (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start,
    input  pg_pkg::grab_ctl_t     ctl,
    output pg_pkg::arm_state_e    state
);
    import pg_pkg::*;

    arm_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (ctl.rearm) begin
            state_nx = ARM_WAIT;
        end else begin
            unique case (state)
                ARM_WAIT: if (frame_start) state_nx = ARM_SEEK;
                ARM_SEEK: if (ctl.hit)     state_nx = ARM_HELD;
                ARM_HELD: if (ctl.consume) state_nx = ARM_WAIT;
                default:                   state_nx = ARM_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ARM_WAIT;
        else     state <= state_nx;
    end

endmodule

// File: rtl/pg_capture_reg.sv
module pg_capture_reg #(
    parameter int PIX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst || clear) dout <= '0;
        else if (load)    dout <= din;
    end

endmodule

// File: rtl/pixel_grabber.sv
module pixel_grabber #(
    parameter  int GRID_DIM = pg_pkg::GRID_DEF,
    parameter  int PIX_W    = pg_pkg::PIX_W_DEF,
    localparam int NUM_PIX  = GRID_DIM * GRID_DIM,
    localparam int IDX_W    = $clog2(NUM_PIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             rd_stb,
    input  logic             wr_stb,
    output logic [PIX_W:0]   grab_reg
);
    import pg_pkg::*;

    arm_state_e       state;
    grab_ctl_t        ctl;
    logic [IDX_W-1:0] cnt_q;
    logic [PIX_W-1:0] data_q;
    logic             held;

    assign held = (state == ARM_HELD);

    always_comb begin
        ctl.rearm   = wr_stb;
        ctl.consume = rd_stb && held && !wr_stb;
        ctl.hit     = (state == ARM_SEEK) && pix_valid && (pix_idx == cnt_q) && !wr_stb;
    end

    pg_arm_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .ctl         (ctl),
        .state       (state)
    );

    pg_index_counter #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.rearm),
        .step  (ctl.consume),
        .cnt   (cnt_q)
    );

    pg_capture_reg #(.PIX_W(PIX_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.rearm || ctl.consume),
        .load  (ctl.hit),
        .din   (pix_data),
        .dout  (data_q)
    );

    assign grab_reg = {held, data_q};

endmodule

// File: rtl/pg_chk.sv
module pg_chk #(
    parameter int NUM_PIX = 225,
    parameter int IDX_W   = 8,
    parameter int PIX_W   = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_valid,
    input logic [IDX_W-1:0] pix_idx,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic [PIX_W:0]   grab_reg,
    input logic [IDX_W-1:0] cnt_q
);

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> grab_reg == '0);

    // R5
    consume_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && grab_reg[PIX_W]) |=> !grab_reg[PIX_W]);

    // R6
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!grab_reg[PIX_W] && !wr_stb) |=> $stable(cnt_q));

    // R8
    write_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (grab_reg == '0 && cnt_q == '0));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (grab_reg[PIX_W] && !rd_stb && !wr_stb) |=> $stable(grab_reg));

    // R4
    match_idx_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grab_reg[PIX_W]) |-> ($past(pix_valid) && $past(pix_idx) == cnt_q));

    // R2
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !grab_reg[PIX_W] |-> grab_reg == '0);

    // R7
    always_comb begin
        if (!rst) begin
            range_chk: assert (int'(cnt_q) < NUM_PIX);
        end
    end

endmodule

bind pixel_grabber pg_chk #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W), .PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_idx   (pix_idx),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .grab_reg  (grab_reg),
    .cnt_q     (cnt_q)
);

// File: tb/tb_pixel_grabber.sv
module tb_pixel_grabber;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_idx = '0;
    logic [6:0] pix_data = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] grab_reg;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    int m_cnt = 0;
    int m_st  = 0;   // 0 waiting for frame, 1 in frame, 2 holding
    int m_dat = 0;

    always #10 clk = ~clk;

    pixel_grabber dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_idx(pix_idx), .pix_data(pix_data), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .grab_reg(grab_reg)
    );

    function automatic int pdata(int i, int f);
        return (i * 3 + f * 5 + 1) % 128;
    endfunction

    function automatic int model_out();
        return (m_st == 2) ? (128 + m_dat) : 0;
    endfunction

    always @(posedge clk) begin
        if (rst || wr_stb) begin
            m_cnt = 0; m_st = 0; m_dat = 0;
        end else begin
            case (m_st)
                0: if (frame_start) m_st = 1;
                1: if (pix_valid && int'(pix_idx) == m_cnt) begin
                       m_dat = int'(pix_data); m_st = 2;
                   end
                default: if (rd_stb) begin
                       m_st = 0; m_dat = 0;
                       m_cnt = (m_cnt == 224) ? 0 : m_cnt + 1;
                   end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_checks++;
            if (int'(grab_reg) != model_out()) begin
                n_fails++;
                $display("FAIL R2 model: got %02h exp %02h", grab_reg, model_out());
            end
        end
    end

    task automatic chk(input int exp, input string tag);
        n_checks++;
        if (int'(grab_reg) != exp) begin
            n_fails++;
            $display("FAIL %s: got %02h exp %02h", tag, grab_reg, exp[7:0]);
        end
    endtask

    task automatic idle();
        frame_start = 0; pix_valid = 0; rd_stb = 0; wr_stb = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic pix(input int i, input int d);
        pix_valid = 1; pix_idx = 8'(i); pix_data = 7'(d);
        cyc();
    endtask

    task automatic fs();
        frame_start = 1;
        cyc();
    endtask

    task automatic rd();
        rd_stb = 1;
        cyc();
    endtask

    task automatic wr();
        wr_stb = 1;
        cyc();
    endtask

    task automatic send_frame(input int f);
        fs();
        for (int i = 0; i < 225; i++) pix(i, pdata(i, f));
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_up();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        chk(0, "R1 reset value");

        pix(0, 7'h11); pix(0, 7'h11);
        chk(0, "R3 pixel before frame start");
        frame_start = 1; pix(0, 7'h22);
        chk(0, "R3 pixel with frame start");
        pix(5, 7'h33);
        chk(0, "R4 wrong index");
        pix(0, 7'h44);
        chk(8'hC4, "R2 capture layout");
        frame_start = 1; pix(0, 7'h55);
        chk(8'hC4, "R9 held value stable");
        rd();
        chk(0, "R5 valid cleared on read");
        rd();
        chk(0, "R6 empty read");
        fs(); pix(0, 7'h66);
        chk(0, "R4 old index after advance");
        pix(1, 7'h77);
        chk(8'hF7, "R6 counter kept at 1");

        wr_stb = 1; rd();
        chk(0, "R8 write beats read");
        fs(); pix(0, 7'h08);
        chk(8'h88, "R8 restart at pixel 0");
        rd();
        fs(); wr();
        pix(0, 7'h09);
        chk(0, "R8 write needs new frame");
        fs(); pix(0, 7'h0A);
        chk(8'h8A, "R8 capture after rearm");
        rd(); wr();

        for (int k = 0; k < 225; k++) begin
            send_frame(k);
            chk(128 + pdata(k, k), "R7 upload pixel");
            rd();
            chk(0, "R5 cleared during upload");
        end
        send_frame(300);
        chk(128 + pdata(0, 300), "R7 wrap to pixel 0");

        finish_up();
    end

endmodule